// File: doc/BRIEF.md
# Watchdog Timer with Delayed Register Commit

This block is a watchdog timer driven through a small word-addressed register port. Software chooses a reload value, turns the count on or off, and refreshes the count by writing any data to a refresh register. If the count runs out while the watchdog is on, the block raises its reset-request output for one cycle and starts the count again from the reload value.

Each write to the reload, control or refresh register is held in a single pending slot and reaches the counter only after a fixed, parameterised number of cycles. This models a write that has to settle in a slower domain before it takes effect. A status register shows which register is still waiting. It also keeps a sticky error flag, which is set when software issues another write before the previous one has landed. A key-protected lock can shut off the timer registers so that stray software cannot change them.

Word indices on `reg_addr` are: 0 reload, 1 current count (read only), 2 control, 3 refresh (write only), 4 lock, 5 status. Reads are combinational from `reg_addr`. A write is taken on the rising clock edge while `reg_wr` is high.

Top module: `wdog_commit`

## Requirements
- R1: After reset the reload register and the current count both read RESET_LOAD (default 1000), the control register reads 0, the lock register reads 0, the status register reads 0, and `rst_req` is low.
- R2: A write to reload, control or refresh that is accepted at clock edge W takes effect at edge W+LAT (LAT defaults to 4). Until then, reads return the old value.
- R3: Status bits report pending writes. Bit 0 is high while any write is pending, bit 1 while a reload write is pending, and bit 2 while a control write is pending. These bits stay high for exactly LAT cycles after the write is accepted.
- R4: A write to reload, control or refresh that arrives while a write is still pending is discarded and sets status bit 3. Bit 3 stays set until software writes a word with bit 3 set to the status register.
- R5: Writing 0x1ACCE551 to the lock register opens the timer registers, and any other value closes them. The lock register reads 1 in bit 0 while closed. While closed, writes to reload, control or refresh are dropped and do not set any status bit.
- R6: A reload write also restarts the current count from the new value when it takes effect. A written value of 0 is stored and read back as 1.
- R7: While enabled (control bit 0 = 1), the count drops by one each cycle. The edge after it reads 0, it reloads and fires a pulse, so successive pulses are reload+1 cycles apart.
- R8: When a refresh write takes effect, the current count is set to the reload value.
- R9: While control bit 0 is 0, the count holds its value and `rst_req` stays low.
- R10: `rst_req` is a single-cycle pulse.
- R11: A pending refresh write sets only status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| rst_req | output | 1 | One-cycle reset request when the count expires |

## Verification
The timeout is measured for several reload values, including 0 and 1. A wrong clamp, a reload that is off by one, or a count that never reloads each gives a measurably different pulse spacing. The commit path is exercised with a single write, with back-to-back writes, and with writes while locked. Status is sampled one cycle before and one cycle after the commit edge, so a latency that is too short or too long shows up, as do an overlap that is not rejected and a locked write that leaks through. Separate sequences apply a refresh while the count runs and hold the count with the watchdog off. These tell a working refresh apart from a plain reload write, and a true hold apart from a count that keeps running.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [2:0] {
    A_LOAD  = 3'd0,
    A_VALUE = 3'd1,
    A_CTRL  = 3'd2,
    A_KICK  = 3'd3,
    A_LOCK  = 3'd4,
    A_STAT  = 3'd5
  } wd_addr_e;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_LOAD = 2'd1,
    K_CTRL = 2'd2,
    K_KICK = 2'd3
  } wd_kind_e;

  localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;

  // R6: a reload of zero is treated as one
  function automatic logic [31:0] clamp_load(input logic [31:0] v);
    return (v == 32'd0) ? 32'd1 : v;
  endfunction

endpackage

// File: rtl/wdog_commit_q.sv
module wdog_commit_q
  import wdog_pkg::*;
#(
  parameter int unsigned LAT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  wd_kind_e    push_kind,
  input  logic [31:0] push_data,
  output logic        busy,
  output wd_kind_e    pend_kind,
  output logic        commit,
  output logic [31:0] commit_data
);
  localparam int unsigned CTW = $clog2(LAT) + 1;

  logic           valid_q;
  logic [CTW-1:0] cnt_q;
  wd_kind_e       kind_q;
  logic [31:0]    data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cnt_q   <= '0;
      kind_q  <= K_NONE;
      data_q  <= '0;
    end else if (push) begin
      valid_q <= 1'b1;
      cnt_q   <= CTW'(LAT - 1);
      kind_q  <= push_kind;
      data_q  <= push_data;
    end else if (valid_q) begin
      if (cnt_q == '0) valid_q <= 1'b0;
      else             cnt_q   <= cnt_q - 1'b1;
    end
  end

  assign busy        = valid_q;
  assign pend_kind   = valid_q ? kind_q : K_NONE;
  assign commit      = valid_q && (cnt_q == '0);
  assign commit_data = data_q;

  // R4: the register front end never pushes over a pending write
  assert_no_push_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !valid_q);
  // R2: the slot stays pending until its countdown ends
  assert_busy_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && cnt_q != '0) |=> valid_q);

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          busy,
  input  wd_kind_e      pend_kind,
  input  logic [CW-1:0] load_q,
  input  logic [CW-1:0] value_q,
  input  logic          en_q,
  output logic          push,
  output wd_kind_e      push_kind
);
  logic locked_q, err_q;
  logic tracked_wr, overlap, clr_err;

  always_comb begin
    unique case (wd_addr_e'(reg_addr))
      A_LOAD:  push_kind = K_LOAD;
      A_CTRL:  push_kind = K_CTRL;
      A_KICK:  push_kind = K_KICK;
      default: push_kind = K_NONE;
    endcase
  end

  assign tracked_wr = reg_wr && (push_kind != K_NONE);
  assign push       = tracked_wr && !locked_q && !busy;
  assign overlap    = tracked_wr && !locked_q && busy;
  assign clr_err    = reg_wr && (wd_addr_e'(reg_addr) == A_STAT) && reg_wdata[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (reg_wr && wd_addr_e'(reg_addr) == A_LOCK)
        locked_q <= (reg_wdata != UNLOCK_KEY);
      if (overlap)      err_q <= 1'b1;
      else if (clr_err) err_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (wd_addr_e'(reg_addr))
      A_LOAD:  reg_rdata = 32'(load_q);
      A_VALUE: reg_rdata = 32'(value_q);
      A_CTRL:  reg_rdata = {31'd0, en_q};
      A_LOCK:  reg_rdata = {31'd0, locked_q};
      A_STAT:  reg_rdata = {28'd0, err_q, pend_kind == K_CTRL,
                            pend_kind == K_LOAD, busy};
      default: reg_rdata = '0;
    endcase
  end

  // R5: a locked, idle block stays idle after a timer write
  assert_locked_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && tracked_wr && !busy) |=> !busy);
  // R4: an overlapping write raises the error flag
  assert_overlap_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    overlap |=> err_q);
  // R4: the error flag only drops on an explicit clear
  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clr_err) |=> err_q);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int unsigned CW         = 32,
  parameter int unsigned RESET_LOAD = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  wd_kind_e      commit_kind,
  input  logic [31:0]   commit_data,
  output logic [CW-1:0] load_q,
  output logic [CW-1:0] value_q,
  output logic          en_q,
  output logic          rst_req
);
  localparam logic [CW-1:0] RST_LD = CW'(clamp_load(32'(RESET_LOAD)));

  logic          do_load, do_kick, do_ctrl;
  logic [CW-1:0] new_load;

  assign do_load  = commit && (commit_kind == K_LOAD);
  assign do_kick  = commit && (commit_kind == K_KICK);
  assign do_ctrl  = commit && (commit_kind == K_CTRL);
  assign new_load = CW'(clamp_load(32'(commit_data[CW-1:0])));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q  <= RST_LD;
      value_q <= RST_LD;
      en_q    <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (do_ctrl) en_q <= commit_data[0];
      if (do_load) begin
        load_q  <= new_load;
        value_q <= new_load;
      end else if (do_kick) begin
        value_q <= load_q;
      end else if (en_q) begin
        if (value_q == '0) begin
          value_q <= load_q;
          rst_req <= 1'b1;
        end else begin
          value_q <= value_q - 1'b1;
        end
      end
    end
  end

  // R10: the reset request never lasts two cycles
  assert_pulse_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R9: a disabled counter holds
  assert_hold_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !commit) |=> $stable(value_q));
  // R6: stored reload is never zero
  assert_load_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_q != '0);
  // R8: refresh copies the reload value into the count
  assert_kick_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    do_kick |=> (value_q == $past(load_q)));

endmodule

// File: rtl/wdog_commit.sv
module wdog_commit
  import wdog_pkg::*;
#(
  parameter int unsigned CW         = 32,
  parameter int unsigned LAT        = 4,
  parameter int unsigned RESET_LOAD = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        rst_req
);
  logic          busy, push, commit, en_q;
  wd_kind_e      pend_kind, push_kind;
  logic [31:0]   commit_data;
  logic [CW-1:0] load_q, value_q;

  wdog_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .pend_kind(pend_kind), .load_q(load_q), .value_q(value_q), .en_q(en_q),
    .push(push), .push_kind(push_kind)
  );

  wdog_commit_q #(.LAT(LAT)) u_q (
    .clk(clk), .rst_n(rst_n), .push(push), .push_kind(push_kind),
    .push_data(reg_wdata), .busy(busy), .pend_kind(pend_kind),
    .commit(commit), .commit_data(commit_data)
  );

  wdog_counter #(.CW(CW), .RESET_LOAD(RESET_LOAD)) u_cnt (
    .clk(clk), .rst_n(rst_n), .commit(commit), .commit_kind(pend_kind),
    .commit_data(commit_data), .load_q(load_q), .value_q(value_q),
    .en_q(en_q), .rst_req(rst_req)
  );

endmodule

// File: tb/test_wdog_commit.sv
module test_wdog_commit;
  localparam int LAT = 4;
  localparam logic [2:0] AD_LOAD = 3'd0, AD_VAL = 3'd1, AD_CTRL = 3'd2,
                         AD_KICK = 3'd3, AD_LOCK = 3'd4, AD_STAT = 3'd5;

  typedef struct packed {
    logic [31:0] ld;
    logic [31:0] rb;
    logic [31:0] per;
  } vec_t;
  localparam vec_t VECS [5] = '{
    '{32'd0,  32'd1,  32'd2},
    '{32'd1,  32'd1,  32'd2},
    '{32'd3,  32'd3,  32'd4},
    '{32'd9,  32'd9,  32'd10},
    '{32'd25, 32'd25, 32'd26}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        rst_req;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  wdog_commit i_wdog_commit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rst_req(rst_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] v2;
    cyc(3);
    rst_n = 1'b1;
    // R1 reset state
    rd(AD_LOAD, v); chk("R1 load", v, 32'd1000);
    rd(AD_VAL, v);  chk("R1 value", v, 32'd1000);
    rd(AD_CTRL, v); chk("R1 ctrl", v, 32'd0);
    rd(AD_LOCK, v); chk("R1 lock", v, 32'd0);
    rd(AD_STAT, v); chk("R1 status", v, 32'd0);
    chk("R1 rst_req", {31'd0, rst_req}, 32'd0);

    // R2/R3 reload commit latency
    wr(AD_LOAD, 32'd20);
    rd(AD_STAT, v); chk("R3 load busy", v, 32'd3);
    rd(AD_LOAD, v); chk("R2 old load", v, 32'd1000);
    cyc(LAT - 1);
    rd(AD_STAT, v); chk("R3 still busy", v, 32'd3);
    rd(AD_LOAD, v); chk("R2 not yet", v, 32'd1000);
    cyc(1);
    rd(AD_STAT, v); chk("R3 idle", v, 32'd0);
    rd(AD_LOAD, v); chk("R2 new load", v, 32'd20);
    rd(AD_VAL, v);  chk("R6 restart", v, 32'd20);

    // R3 control busy, R11 refresh busy
    wr(AD_CTRL, 32'd0);
    rd(AD_STAT, v); chk("R3 ctrl busy", v, 32'd5);
    cyc(LAT);
    wr(AD_KICK, 32'hDEAD);
    rd(AD_STAT, v); chk("R11 kick busy", v, 32'd1);
    cyc(LAT);

    // R4 overlapping write
    wr(AD_LOAD, 32'd50);
    wr(AD_LOAD, 32'd77);
    rd(AD_STAT, v); chk("R4 err set", v, 32'hB);
    cyc(LAT - 2);
    rd(AD_STAT, v); chk("R4 err sticky", v, 32'h8);
    rd(AD_LOAD, v); chk("R4 discarded", v, 32'd50);
    wr(AD_STAT, 32'd0);
    rd(AD_STAT, v); chk("R4 no clear w/o bit3", v, 32'h8);
    wr(AD_STAT, 32'd8);
    rd(AD_STAT, v); chk("R4 cleared", v, 32'h0);

    // R5 lock
    wr(AD_LOCK, 32'd0);
    rd(AD_LOCK, v); chk("R5 locked", v, 32'd1);
    wr(AD_LOAD, 32'd99);
    rd(AD_STAT, v); chk("R5 no busy", v, 32'd0);
    wr(AD_CTRL, 32'd1);
    cyc(LAT + 1);
    rd(AD_LOAD, v); chk("R5 load kept", v, 32'd50);
    rd(AD_CTRL, v); chk("R5 ctrl kept", v, 32'd0);
    wr(AD_LOCK, 32'h1ACCE551);
    rd(AD_LOCK, v); chk("R5 unlocked", v, 32'd0);

    // R9 hold while disabled
    rd(AD_VAL, v); chk("R9 value", v, 32'd50);
    cyc(10);
    rd(AD_VAL, v); chk("R9 hold", v, 32'd50);

    // R8 refresh while running
    wr(AD_LOAD, 32'd30); cyc(LAT);
    wr(AD_CTRL, 32'd1);  cyc(LAT);
    rd(AD_VAL, v); chk("R7 start", v, 32'd30);
    cyc(10);
    rd(AD_VAL, v); chk("R7 decrement", v, 32'd20);
    wr(AD_KICK, 32'd0);
    cyc(LAT);
    rd(AD_VAL, v); chk("R8 refresh", v, 32'd30);

    // R7/R6/R10 timeout period table
    foreach (VECS[i]) begin
      int n;
      int per;
      wr(AD_LOAD, VECS[i].ld); cyc(LAT);
      rd(AD_LOAD, v); chk("R6 readback", v, VECS[i].rb);
      n = 0;
      while (rst_req !== 1'b1 && n < 200) begin cyc(1); n++; end
      chk("R7 first pulse", {31'd0, rst_req}, 32'd1);
      per = 0;
      cyc(1); per++;
      chk("R10 one cycle", {31'd0, rst_req}, 32'd0);
      while (rst_req !== 1'b1 && per < 200) begin cyc(1); per++; end
      chk("R7 period", 32'(per), VECS[i].per);
    end

    // R9 disabled: no pulses, count stable
    wr(AD_CTRL, 32'd0); cyc(LAT + 1);
    rd(AD_VAL, v);
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < 60; k++) begin cyc(1); if (rst_req) seen++; end
      chk("R9 no pulse", 32'(seen), 32'd0);
    end
    rd(AD_VAL, v2); chk("R9 stable", v2, v);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule